// File: doc/BRIEF.md
# Row-Buffered Array Writer with Timed Commit

This block stands between a two-wire serial slave engine and a byte-wide nonvolatile array. When the engine has decoded a write select and the address byte, it tells the block where the write begins. Each data byte the engine accepts is then placed in a small row buffer. The slot that receives a byte is chosen by the low address bits only, and those bits wrap at the end of the row. The upper address bits stay fixed for the whole transaction. A 16-bit mask records which slots have received data.

The buffer reaches the array only if the transaction ends with a Stop that falls directly after an acknowledge slot. Any other ending throws the buffer away. After a commit, the block drains the marked slots to the array write port, one byte per cycle, and holds a busy flag for a fixed, parameterised number of cycles. This window models the self-timed programming cycle. The slave engine uses busy to stay silent on the bus, so it acknowledges nothing, not even its own select byte, until busy drops. The engine also passes in a protect flag that is sticky from Start to the end of the address byte. A protected transaction writes nothing.

Top module: `pwb_top`

## Requirements
- R1: While reset is held and on the first cycle after release, `busy` and `mem_we` are both 0.
- R2: `wr_begin` loads the row from `wr_addr[AW-1:4]` and the starting slot from `wr_addr[3:0]`. Each `byte_vld` stores `byte_data` in the current slot and advances only the 4-bit slot number, so slot 15 is followed by slot 0 of the same row.
- R3: When more than 16 bytes are sent, a later byte that lands in an already filled slot replaces the earlier one. Only the newest value of each slot is written.
- R4: A `stop_evt` with `stop_at_ack`=1 commits the buffer. A `stop_evt` with `stop_at_ack`=0 discards it, and the array port never strobes.
- R5: When `wr_prot` is 1 at `wr_begin`, the bytes of that transaction are dropped. Nothing is written and busy is not raised.
- R6: After a commit, one `mem_we` pulse is issued for each filled slot and no others. The pulses come on consecutive cycles in ascending slot order, starting in the cycle after the Stop. Their address is {row, slot}.
- R7: `busy` rises in the cycle after a committing Stop and stays high for exactly `TW_CYCLES` cycles. `TW_CYCLES` is raised to 16 if it is set lower.
- R8: While `busy` is high, `wr_begin`, `byte_vld` and `stop_evt` are ignored. They cause no extra writes and do not extend the busy window.
- R9: A `wr_begin` that arrives while a buffer is being filled discards the previously buffered bytes.
- R10: A commit with no filled slot (an address-only write) causes no write and no busy window. `mem_we` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_begin | input | 1 | Write transaction start, pulsed after the address byte |
| wr_addr | input | AW | Base array address of the transaction |
| wr_prot | input | 1 | Sticky protect status for this transaction |
| byte_vld | input | 1 | One accepted data byte |
| byte_data | input | 8 | Data byte |
| stop_evt | input | 1 | Stop condition seen |
| stop_at_ack | input | 1 | Stop fell directly after an acknowledge slot |
| busy | output | 1 | Programming window active |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
On every cycle, the assertions check three things. A write strobe only appears inside the busy window. Successive strobes in one drain climb through the slots of a single row. Each busy window opens only after a committing Stop and lasts exactly the programmed length. Wrap-around overwriting, discard on a misplaced Stop or a restart, protect suppression, and the final contents of the array can only be shown by the bench's scenarios. The bench compares a byte-level model of the array that it builds from the requirements against the writes it observes.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PWB_IDLE = 2'd0,
    PWB_FILL = 2'd1,
    PWB_BUSY = 2'd2
  } pwb_state_e;

  // The busy window must be long enough to drain a full row.
  function automatic int unsigned pwb_hold_len(input int unsigned tw, input int unsigned page);
    return (tw < page) ? page : tw;
  endfunction
endpackage

// File: rtl/pwb_row_buf.sv
module pwb_row_buf #(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  wr_en_i,
  input  logic [OFF_W-1:0]      wr_off_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  drn_en_i,
  input  logic [OFF_W-1:0]      drn_off_i,
  output logic [PAGE_BYTES-1:0] fill_mask_o,
  output logic [DATA_W-1:0]     drn_data_o
);
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PAGE_BYTES-1:0] mask_d;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit_wr;
    logic hit_drn;
    assign hit_wr  = wr_en_i  && (wr_off_i  == OFF_W'(g));
    assign hit_drn = drn_en_i && (drn_off_i == OFF_W'(g));

    // Data slots carry no reset; the mask alone says what is valid.
    always_ff @(posedge clk) begin
      if (hit_wr) slot_q[g] <= wr_data_i;
    end

    always_comb begin
      mask_d[g] = mask_q[g];
      if (clr_i)        mask_d[g] = 1'b0;
      else if (hit_wr)  mask_d[g] = 1'b1;
      else if (hit_drn) mask_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign fill_mask_o = mask_q;
  assign drn_data_o  = slot_q[drn_off_i];
endmodule

// File: rtl/pwb_pick.sv
module pwb_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // Lowest set bit wins, giving an ascending drain order.
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned HOLD = 16,
  localparam int unsigned CW  = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                     cnt_d = CW'(HOLD - 1);
    else if (run_i && cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int unsigned AW         = 11,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned TW_CYCLES  = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_begin,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_prot,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          stop_evt,
  input  logic          stop_at_ack,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned ROW_W  = AW - OFF_W;
  localparam int unsigned TW_EFF = pwb_hold_len(TW_CYCLES, PAGE_BYTES);

  pwb_state_e        state_q, state_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              prot_q, prot_d;

  logic                  buf_clr;
  logic                  buf_wr;
  logic                  tmr_load;
  logic                  tmr_done;
  logic                  drn_any;
  logic                  drn_en;
  logic [OFF_W-1:0]      drn_idx;
  logic [PAGE_BYTES-1:0] fill_mask;
  logic [7:0]            drn_data;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    row_d    = row_q;
    off_d    = off_q;
    prot_d   = prot_q;
    buf_clr  = 1'b0;
    buf_wr   = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      PWB_IDLE: begin
        if (wr_begin) begin
          state_d = PWB_FILL;
          row_d   = wr_addr[AW-1:OFF_W];
          off_d   = wr_addr[OFF_W-1:0];
          prot_d  = wr_prot;
          buf_clr = 1'b1;
        end
      end
      PWB_FILL: begin
        if (wr_begin) begin
          row_d   = wr_addr[AW-1:OFF_W];
          off_d   = wr_addr[OFF_W-1:0];
          prot_d  = wr_prot;
          buf_clr = 1'b1;
        end else if (stop_evt) begin
          if (stop_at_ack && !prot_q && (|fill_mask)) begin
            state_d  = PWB_BUSY;
            tmr_load = 1'b1;
          end else begin
            state_d = PWB_IDLE;
            buf_clr = 1'b1;
          end
        end else if (byte_vld) begin
          buf_wr = !prot_q;
          off_d  = off_q + OFF_W'(1);
        end
      end
      PWB_BUSY: begin
        if (tmr_done) state_d = PWB_IDLE;
      end
      default: state_d = PWB_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWB_IDLE;
      row_q   <= '0;
      off_q   <= '0;
      prot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      off_q   <= off_d;
      prot_q  <= prot_d;
    end
  end

  assign busy   = (state_q == PWB_BUSY);
  assign drn_en = busy && drn_any;

  pwb_row_buf #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (8)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (buf_clr),
    .wr_en_i    (buf_wr),
    .wr_off_i   (off_q),
    .wr_data_i  (byte_data),
    .drn_en_i   (drn_en),
    .drn_off_i  (drn_idx),
    .fill_mask_o(fill_mask),
    .drn_data_o (drn_data)
  );

  pwb_pick #(.N(PAGE_BYTES)) u_pick (
    .req_i(fill_mask),
    .any_o(drn_any),
    .idx_o(drn_idx)
  );

  pwb_timer #(.HOLD(TW_EFF)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(tmr_load),
    .run_i (busy),
    .done_o(tmr_done)
  );

  assign mem_we    = drn_en;
  assign mem_addr  = {row_q, drn_idx};
  assign mem_wdata = drn_data;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk
  import pwb_pkg::*;
#(
  parameter int unsigned AW         = 11,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned TW_CYCLES  = 250000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_evt,
  input logic          stop_at_ack,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned TW_EFF = pwb_hold_len(TW_CYCLES, PAGE_BYTES);
  localparam int unsigned RW     = $clog2(TW_EFF + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + RW'(1);
    else           run_q <= '0;
  end

  // R10: strobes only inside the busy window
  a_r10_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R6: drain climbs through the slots of one row
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0])) && $stable(mem_addr[AW-1:OFF_W]));

  // R4, R7: busy opens only after a Stop that follows an acknowledge slot
  a_r7_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt && stop_at_ack));

  // R7: busy never outlasts its window
  a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RW'(TW_EFF)));

  // R7: busy closes exactly at the end of its window
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RW'(TW_EFF)));
endmodule

bind pwb_top pwb_chk #(
  .AW        (AW),
  .PAGE_BYTES(PAGE_BYTES),
  .TW_CYCLES (TW_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_evt   (stop_evt),
  .stop_at_ack(stop_at_ack),
  .busy       (busy),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr)
);

// File: tb/sim_pwb_top.sv
`timescale 1ns/1ps
module sim_pwb_top;
  localparam int AW   = 11;
  localparam int TW   = 24;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_begin, wr_prot, byte_vld, stop_evt, stop_at_ack;
  logic [AW-1:0] wr_addr;
  logic [7:0]    byte_data;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  always #10 clk = ~clk;

  pwb_top #(.AW(AW), .PAGE_BYTES(16), .TW_CYCLES(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .wr_prot(wr_prot), .byte_vld(byte_vld), .byte_data(byte_data),
    .stop_evt(stop_evt), .stop_at_ack(stop_at_ack), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int nchk = 0;
  int nerr = 0;
  logic [7:0] model [MEMN];
  logic [7:0] expm  [MEMN];
  int wcnt, bcnt, first_a;

  // Vector: {addr[11], nbytes[6], first data[8], stop_at_ack, protect}
  localparam logic [26:0] VEC [8] = '{
    {11'h005, 6'd1,  8'h11, 1'b1, 1'b0},
    {11'h120, 6'd16, 8'h40, 1'b1, 1'b0},
    {11'h23C, 6'd6,  8'h80, 1'b1, 1'b0},
    {11'h310, 6'd20, 8'hA0, 1'b1, 1'b0},
    {11'h400, 6'd4,  8'h55, 1'b0, 1'b0},
    {11'h500, 6'd3,  8'h66, 1'b1, 1'b1},
    {11'h600, 6'd0,  8'h00, 1'b1, 1'b0},
    {11'h7F8, 6'd2,  8'h01, 1'b1, 1'b0}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) bcnt++;
      if (mem_we) begin
        model[mem_addr] = mem_wdata;
        if (wcnt == 0) first_a = int'(mem_addr);
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    wcnt = 0; bcnt = 0; first_a = -1;
  endtask

  task automatic begin_w(input logic [AW-1:0] a, input bit p);
    wr_begin = 1'b1; wr_addr = a; wr_prot = p;
    @(negedge clk);
    wr_begin = 1'b0;
  endtask

  task automatic send_bytes(input int n, input logic [7:0] d);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_data = d + 8'(i);
      @(negedge clk);
      byte_vld = 1'b0;
    end
  endtask

  task automatic send_stop(input bit ok, output logic b);
    stop_evt = 1'b1; stop_at_ack = ok;
    @(negedge clk);
    stop_evt = 1'b0; stop_at_ack = 1'b0;
    b = busy;
  endtask

  task automatic exp_apply(input logic [AW-1:0] a, input int n, input logic [7:0] d,
                           input bit ok, input bit p);
    if (ok && !p && n > 0) begin
      for (int i = 0; i < n; i++) begin
        logic [3:0] o;
        o = a[3:0] + 4'(i);
        expm[{a[AW-1:4], o}] = d + 8'(i);
      end
    end
  endtask

  task automatic cmp_model(input string req);
    int bad = 0;
    int fa = 0;
    for (int i = 0; i < MEMN; i++) begin
      if (model[i] !== expm[i]) begin
        if (bad == 0) fa = i;
        bad++;
      end
    end
    if (bad != 0) chk(1'b0, req, int'(model[fa]), int'(expm[fa]));
    else          chk(1'b1, req, 0, 0);
  endtask

  task automatic settle();
    repeat (TW + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic b;
    for (int i = 0; i < MEMN; i++) begin
      model[i] = 8'hFF; expm[i] = 8'hFF;
    end
    clr_mon();
    rst_n = 1'b0; wr_begin = 0; wr_prot = 0; byte_vld = 0; stop_evt = 0;
    stop_at_ack = 0; wr_addr = '0; byte_data = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1 in reset", {busy, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1 after release", {busy, mem_we}, 0);

    // Table-driven walk: R2 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < 8; v++) begin
      logic [AW-1:0] a;
      int n, lo;
      logic [7:0] d;
      bit ok, p, com;
      a = VEC[v][26:16]; n = int'(VEC[v][15:10]); d = VEC[v][9:2];
      ok = VEC[v][1]; p = VEC[v][0];
      com = ok && !p && (n > 0);
      clr_mon();
      begin_w(a, p);
      send_bytes(n, d);
      send_stop(ok, b);
      settle();
      exp_apply(a, n, d, ok, p);
      chk(b == com, "R7 busy after stop", int'(b), int'(com));
      chk(bcnt == (com ? TW : 0), "R7 busy length", bcnt, com ? TW : 0);
      chk(wcnt == (com ? ((n > 16) ? 16 : n) : 0), "R6 write count", wcnt,
          com ? ((n > 16) ? 16 : n) : 0);
      cmp_model("R2 R3 R4 R5 array contents");
      if (com) begin
        lo = (int'(a[3:0]) + n > 16) ? 0 : int'(a[3:0]);
        chk(first_a == ((int'(a) & ~15) | lo), "R6 first slot", first_a,
            (int'(a) & ~15) | lo);
      end
    end

    // R8: a full transaction during busy is ignored
    clr_mon();
    begin_w(11'h080, 1'b0);
    send_bytes(2, 8'hC0);
    send_stop(1'b1, b);
    begin_w(11'h090, 1'b0);
    send_bytes(3, 8'hD0);
    send_stop(1'b1, b);
    chk(b == 1'b1, "R8 still busy", int'(b), 1);
    settle();
    exp_apply(11'h080, 2, 8'hC0, 1'b1, 1'b0);
    chk(wcnt == 2, "R8 no extra writes", wcnt, 2);
    chk(bcnt == TW, "R8 window not extended", bcnt, TW);
    cmp_model("R8 array contents");

    // R9: restart while filling drops earlier bytes
    clr_mon();
    begin_w(11'h0A0, 1'b0);
    send_bytes(2, 8'hE0);
    begin_w(11'h0B0, 1'b0);
    send_bytes(1, 8'hF0);
    send_stop(1'b1, b);
    settle();
    exp_apply(11'h0B0, 1, 8'hF0, 1'b1, 1'b0);
    chk(wcnt == 1, "R9 single write", wcnt, 1);
    chk(first_a == 'h0B0, "R9 write address", first_a, 'h0B0);
    cmp_model("R9 array contents");

    // R4: misplaced stop after a wrapped fill, then a clean one-byte write
    clr_mon();
    begin_w(11'h6FE, 1'b0);
    send_bytes(5, 8'h30);
    send_stop(1'b0, b);
    settle();
    chk(wcnt == 0 && bcnt == 0, "R4 discard", wcnt + bcnt, 0);
    cmp_model("R4 array after discard");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule